// File: doc/BRIEF.md
# Sixteen-Channel Fixed-to-Float Rescaling Streamer

This block converts a frame of sixteen signed fixed-point analog samples into single-precision floating-point values. Each value is rescaled with its own gain and offset. The samples arrive two per input word, on eight words. A one-cycle sync pulse captures all sixteen samples at once. One shared multiply-add then walks through the channels in index order, and a combinational fixed-to-float converter rounds each result.

The results leave the block by two routes. The first is a serial word stream that carries one channel per cycle, with a valid flag and a last flag in its two low bits. The second is a bank of sixteen float registers. The whole bank changes in the single cycle that channel 15 leaves the stream, and a done strobe marks that cycle.

Gains and offsets are loaded through a small write-only port. A sync pulse that arrives too soon after the previous accepted one is dropped, and a sticky overrun flag records the event.

Top module: `rescale_streamer`

## Requirements
- R1: Input word k carries channel 2k in bits 15:0 and channel 2k+1 in bits 31:16, each a signed 16-bit value with 10 fractional bits. Bit 32 of every word has no effect on any result.
- R2: Channel i yields the IEEE single-precision value of x*gain[i] + offset[i]. Gain is signed 16-bit with 14 fractional bits. Offset is signed 32-bit with 24 fractional bits. The result is rounded to nearest, with ties going to even, and an exact zero gives 0x00000000.
- R3: A write with cfg_we high stores cfg_wdata for the channel given by cfg_addr[3:0]. When cfg_addr[4] is 0 it stores the gain, taken from cfg_wdata[15:0]. When cfg_addr[4] is 1 it stores the full 32-bit offset.
- R4: In ser_out, bit 0 is last, bit 1 is valid and bits 33:2 hold the float. The stream sends channels 0 to 15 on sixteen consecutive cycles. Channel 0 appears three rising edges after the edge that accepts sync.
- R5: last is high only together with channel 15, and never while valid is low. valid stays low outside the sixteen data cycles.
- R6: The samples are captured on the edge that accepts sync. Input changes after that edge do not alter the results of the pass.
- R7: A sync that arrives during the 16 edges after an accepted one is ignored and leaves the stream unchanged. It sets overrun, and overrun stays set until reset.
- R8: A sync that arrives 17 cycles after the previous accepted one is accepted without setting overrun.
- R9: All sixteen par_out entries change together in the cycle that carries channel 15, and done is high for exactly that cycle. At all other times par_out holds its value.
- R10: After reset, ser_out, par_out, done and overrun are zero, every gain is 1.0 (0x4000) and every offset is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Starts one rescaling pass |
| pair_in | input | 8x33 | Packed sample pairs |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 5 | Bit 4 selects offset; bits 3:0 select the channel |
| cfg_wdata | input | 32 | Coefficient write data |
| par_out | output | 16x32 | Float bank, entry i holds channel i |
| ser_out | output | 34 | {float, valid, last} stream word |
| done | output | 1 | One-cycle pulse when a pass completes |
| overrun | output | 1 | Sticky flag for a dropped sync |

## Verification
Channel k of the stream is due k+3 edges after the edge that accepts sync. done and the bank update are due 18 edges after it, and the bank must still hold its old contents at edge 17. The bench drives sync, stimulus and writes on falling edges and counts rising edges from the accepting one. It samples at the next falling edge, which lets it require each valid beat at its exact cycle rather than waiting for it. Back-to-back passes are chained at edge 17, and disturbing syncs land at edge 6, so each timing boundary is hit exactly.

// File: rtl/rescale_pkg.sv
// Shared constants and types for the rescaling streamer.
// Assumes IEEE single precision for every float result.
package rescale_pkg;
    localparam int FLT_W  = 32;
    localparam int MANT_W = 23;
    localparam int EXP_W  = 8;
    localparam int BIAS   = 127;
    typedef logic [FLT_W-1:0] flt_t;
endpackage

// File: rtl/fix_to_float.sv
// Combinational conversion of a signed fixed-point value (FRAC fractional
// bits) to IEEE single precision, round to nearest even.
// Assumes IN_W >= 26 and a magnitude that stays in the normal float range.
module fix_to_float
    import rescale_pkg::*;
#(
    parameter int IN_W = 33,
    parameter int FRAC = 24
) (
    input  logic signed [IN_W-1:0] val,
    output flt_t                   flt
);
    localparam int LW = $clog2(IN_W);

    logic [IN_W-1:0]   mag;
    logic [IN_W-1:0]   norm;
    logic [LW-1:0]     lead;
    logic [MANT_W-1:0] mant;
    logic [MANT_W-1:0] mant_r;
    logic              guard;
    logic              sticky;
    logic              rnd;
    logic              carry;
    logic [9:0]        e_w;

    // Magnitude and position of the leading one.
    always_comb begin
        mag  = val[IN_W-1] ? (~val + 1'b1) : val;
        lead = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (mag[i]) lead = LW'(i);
        end
    end

    // Normalise, round to nearest even, and pack the fields.
    always_comb begin
        norm   = mag << (LW'(IN_W - 1) - lead);
        mant   = norm[IN_W-2 -: MANT_W];
        guard  = norm[IN_W-2-MANT_W];
        sticky = |norm[IN_W-3-MANT_W:0];
        rnd    = guard & (sticky | mant[0]);
        {carry, mant_r} = {1'b0, mant} + (MANT_W+1)'(rnd);
        e_w    = 10'(lead) + 10'(BIAS - FRAC) + 10'(carry);
        if (mag == '0) flt = '0;
        else           flt = {val[IN_W-1], e_w[EXP_W-1:0], mant_r};
    end
endmodule

// File: rtl/coef_bank.sv
// Per-channel gain and offset registers with one write port and one
// combinational read port. Address MSB selects offset; low bits select channel.
// Assumes gain has GAIN_FRAC fractional bits; reset loads unity gain, zero offset.
module coef_bank #(
    parameter int N_CH      = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int OFS_W     = 32,
    parameter int ADDR_W    = $clog2(N_CH) + 1,
    parameter int IDX_W     = $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [OFS_W-1:0]         wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [GAIN_W-1:0] rd_gain,
    output logic signed [OFS_W-1:0]  rd_ofs
);
    localparam logic signed [GAIN_W-1:0] UNITY = GAIN_W'(1) << GAIN_FRAC;

    logic signed [GAIN_W-1:0] gain_q [N_CH];
    logic signed [OFS_W-1:0]  ofs_q  [N_CH];

    // Store a gain or an offset on a configuration write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (!rst_n) begin
                gain_q[i] <= UNITY;
                ofs_q[i]  <= '0;
            end else if (wr_en && wr_addr[IDX_W-1:0] == IDX_W'(i)) begin
                if (wr_addr[ADDR_W-1]) ofs_q[i]  <= wr_data;
                else                   gain_q[i] <= wr_data[GAIN_W-1:0];
            end
        end
    end

    // Coefficients for the channel the pipeline is issuing.
    always_comb begin
        rd_gain = gain_q[rd_idx];
        rd_ofs  = ofs_q[rd_idx];
    end
endmodule

// File: rtl/rescale_seq.sv
// Pass sequencer: accepts sync while idle, then issues channel indices
// 0..N_CH-1 on consecutive cycles. Sync while busy raises a sticky overrun.
// Assumes sync is synchronous to clk.
module rescale_seq #(
    parameter int N_CH  = 16,
    parameter int IDX_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             capture,
    output logic             issue_vld,
    output logic [IDX_W-1:0] issue_idx,
    output logic             overrun
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CH - 1);

    logic             busy;
    logic [IDX_W-1:0] idx;

    assign capture   = sync && !busy;
    assign issue_vld = busy;
    assign issue_idx = idx;

    // Walk the channel index during a pass; flag syncs that arrive too early.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            overrun <= 1'b0;
        end else begin
            if (capture) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                idx <= idx + 1'b1;
                if (idx == LAST) busy <= 1'b0;
            end
            if (sync && busy) overrun <= 1'b1;
        end
    end

    p_early_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && busy) |=> overrun);
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !busy) |=> (busy && idx == '0));
    p_pass_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx == LAST && !sync) |=> !busy);
endmodule

// File: rtl/rescale_streamer.sv
// Top: unpacks sample pairs, snapshots them on sync, runs one shared
// multiply-add per cycle, converts to float and emits a serial stream plus
// a parallel bank that commits when the last channel leaves.
// Assumes the offset carries SAMP_FRAC+GAIN_FRAC fractional bits.
module rescale_streamer
    import rescale_pkg::*;
#(
    parameter int N_CH      = 16,
    parameter int SAMP_W    = 16,
    parameter int SAMP_FRAC = 10,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int OFS_W     = 32,
    parameter int WORD_W    = 33,
    parameter int ADDR_W    = $clog2(N_CH) + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sync,
    input  logic [N_CH/2-1:0][WORD_W-1:0]     pair_in,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [OFS_W-1:0]                  cfg_wdata,
    output logic [N_CH-1:0][FLT_W-1:0]        par_out,
    output logic [FLT_W+1:0]                  ser_out,
    output logic                              done,
    output logic                              overrun
);
    localparam int N_WORD = N_CH / 2;
    localparam int IDX_W  = $clog2(N_CH);
    localparam int PROD_W = SAMP_W + GAIN_W;
    localparam int SUM_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 1;
    localparam int SUM_FR = SAMP_FRAC + GAIN_FRAC;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CH - 1);

    logic                     capture;
    logic                     issue_vld;
    logic [IDX_W-1:0]         issue_idx;
    logic signed [GAIN_W-1:0] rd_gain;
    logic signed [OFS_W-1:0]  rd_ofs;

    logic signed [SAMP_W-1:0] snap_q [N_CH];

    logic                     a_vld;
    logic [IDX_W-1:0]         a_idx;
    logic signed [SAMP_W-1:0] a_x;
    logic signed [GAIN_W-1:0] a_g;
    logic signed [OFS_W-1:0]  a_o;
    logic signed [PROD_W-1:0] a_prod;

    logic                     b_vld;
    logic [IDX_W-1:0]         b_idx;
    logic signed [SUM_W-1:0]  b_sum;
    flt_t                     b_flt;

    logic                     c_vld;
    logic                     c_last;
    logic [IDX_W-1:0]         c_idx;
    flt_t                     c_flt;
    flt_t                     shadow_q [N_CH];

    rescale_seq #(.N_CH(N_CH), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (sync),
        .capture   (capture),
        .issue_vld (issue_vld),
        .issue_idx (issue_idx),
        .overrun   (overrun)
    );

    coef_bank #(
        .N_CH(N_CH), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
        .OFS_W(OFS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_idx  (issue_idx),
        .rd_gain (rd_gain),
        .rd_ofs  (rd_ofs)
    );

    // Bits above the two packed samples carry nothing for this block.
    generate
        if (WORD_W > 2 * SAMP_W) begin : g_spare
            logic unused_spare;
            always_comb begin
                unused_spare = 1'b0;
                for (int w = 0; w < N_WORD; w++)
                    unused_spare = unused_spare ^ (^pair_in[w][WORD_W-1:2*SAMP_W]);
            end
        end
    endgenerate

    // Capture all channels from their pair words on an accepted sync.
    always_ff @(posedge clk) begin
        for (int w = 0; w < N_WORD; w++) begin
            if (!rst_n) begin
                snap_q[2*w]   <= '0;
                snap_q[2*w+1] <= '0;
            end else if (capture) begin
                snap_q[2*w]   <= pair_in[w][SAMP_W-1:0];
                snap_q[2*w+1] <= pair_in[w][2*SAMP_W-1:SAMP_W];
            end
        end
    end

    // Stage A: fetch the issued sample and its coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
            a_idx <= '0;
            a_x   <= '0;
            a_g   <= '0;
            a_o   <= '0;
        end else begin
            a_vld <= issue_vld;
            a_idx <= issue_idx;
            a_x   <= snap_q[issue_idx];
            a_g   <= rd_gain;
            a_o   <= rd_ofs;
        end
    end

    assign a_prod = a_x * a_g;

    // Stage B: shared multiply-add in fixed point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld <= 1'b0;
            b_idx <= '0;
            b_sum <= '0;
        end else begin
            b_vld <= a_vld;
            b_idx <= a_idx;
            b_sum <= SUM_W'(a_prod) + SUM_W'(a_o);
        end
    end

    fix_to_float #(.IN_W(SUM_W), .FRAC(SUM_FR)) u_cvt (
        .val (b_sum),
        .flt (b_flt)
    );

    // Stage C: serial stream word for the converted channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_vld  <= 1'b0;
            c_last <= 1'b0;
            c_idx  <= '0;
            c_flt  <= '0;
        end else begin
            c_vld  <= b_vld;
            c_last <= b_vld && b_idx == LAST;
            c_idx  <= b_idx;
            c_flt  <= b_vld ? b_flt : '0;
        end
    end

    // Collect results in a shadow and commit the whole bank with the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            for (int i = 0; i < N_CH; i++) begin
                shadow_q[i] <= '0;
                par_out[i]  <= '0;
            end
        end else begin
            done <= b_vld && b_idx == LAST;
            for (int i = 0; i < N_CH; i++) begin
                if (b_vld && b_idx == IDX_W'(i)) shadow_q[i] <= b_flt;
                if (b_vld && b_idx == LAST)
                    par_out[i] <= (i == N_CH - 1) ? b_flt : shadow_q[i];
            end
        end
    end

    assign ser_out = {c_flt, c_vld, c_last};

    p_last_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out[0] |-> ser_out[1]);
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_vld && c_idx != LAST) |=> (c_vld && c_idx == $past(c_idx) + 1'b1));
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(par_out));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> c_flt[FLT_W-2 -: EXP_W] != '1);
endmodule

// File: tb/rescale_streamer_bench.sv
module rescale_streamer_bench;
    localparam int N = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sync = 1'b0;
    logic [7:0][32:0]     pair_in = '0;
    logic                 cfg_we = 1'b0;
    logic [4:0]           cfg_addr = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [N-1:0][31:0]   par_out;
    logic [33:0]          ser_out;
    logic                 done;
    logic                 overrun;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit exp_ovr = 0;

    logic signed [15:0] bx [N];
    logic signed [15:0] gm [N];
    logic signed [31:0] om [N];
    logic [31:0] ex_cur [N];
    logic [31:0] ex_nxt [N];
    logic [31:0] par_prev [N];

    rescale_streamer u_rescale_streamer (
        .clk(clk), .rst_n(rst_n), .sync(sync), .pair_in(pair_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .par_out(par_out), .ser_out(ser_out), .done(done), .overrun(overrun)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp<=50000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // Float reference built from real arithmetic, round to nearest even.
    function automatic logic [31:0] to_f32(input longint v);
        real r, p, m, fr;
        longint mi;
        int e;
        logic s;
        logic [7:0] ef;
        if (v == 0) return 32'h0;
        s = (v < 0);
        r = s ? real'(-v) : real'(v);
        e = 0;
        p = 1.0;
        while (r >= 2.0 * p) begin p = 2.0 * p; e++; end
        m  = r / p * 8388608.0;
        mi = longint'($floor(m));
        fr = m - real'(mi);
        if (fr > 0.5 || (fr == 0.5 && mi[0])) mi++;
        if (mi == 64'd16777216) begin mi = 64'd8388608; e++; end
        ef = 8'(e - 24 + 127);
        return {s, ef, mi[22:0]};
    endfunction

    function automatic void calc_nxt();
        for (int i = 0; i < N; i++)
            ex_nxt[i] = to_f32(longint'(bx[i]) * longint'(gm[i]) + longint'(om[i]));
    endfunction

    function automatic logic [7:0][32:0] pack();
        logic [7:0][32:0] w;
        for (int k = 0; k < 8; k++)
            w[k] = {1'($urandom), bx[2*k+1], bx[2*k]};
        return w;
    endfunction

    function automatic void rand_bx();
        for (int i = 0; i < N; i++) bx[i] = 16'($urandom);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        pair_in = pack();
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
    endtask

    // c counts rising edges after the edge that accepted sync.
    task automatic observe(input int first_c, input int last_c, input bit poke, input bit chain);
        int beats = 0;
        for (int c = first_c; c <= last_c; c++) begin
            @(negedge clk);
            if (ser_out[1]) begin
                chk(c == beats + 3, "R4 beat timing", c, beats + 3);
                if (beats < N)
                    chk(ser_out[33:2] == ex_cur[beats], "R1/R2 channel value", ser_out[33:2], ex_cur[beats]);
                chk(ser_out[0] == (beats == N - 1), "R5 last with ch15", ser_out[0], beats == N - 1);
                beats++;
            end else begin
                chk(ser_out[0] == 1'b0, "R5 last without valid", ser_out[0], 0);
            end
            chk(done == (c == 18), "R9 done strobe", done, c == 18);
            if (c == 17) begin
                bit ok = 1;
                for (int i = 0; i < N; i++) if (par_out[i] != par_prev[i]) ok = 0;
                chk(ok, "R9 bank holds before commit", par_out[0], par_prev[0]);
            end
            if (c == 18) begin
                for (int i = 0; i < N; i++)
                    chk(par_out[i] == ex_cur[i], "R9 bank commit", par_out[i], ex_cur[i]);
            end
            if (poke && c == 5) begin
                sync = 1'b1;
                for (int k = 0; k < 8; k++) pair_in[k] = {$urandom, 1'($urandom)};
                exp_ovr = 1;
            end
            if (poke && c == 6) sync = 1'b0;
            if (chain && c == 16) begin
                rand_bx();
                calc_nxt();
                pair_in = pack();
                sync = 1'b1;
            end
            if (chain && c == 17) sync = 1'b0;
        end
        chk(beats == N, "R4 beat count", beats, N);
    endtask

    task automatic one_pass(input bit poke);
        calc_nxt();
        for (int i = 0; i < N; i++) ex_cur[i] = ex_nxt[i];
        fire();
        observe(1, 22, poke, 0);
        for (int i = 0; i < N; i++) par_prev[i] = ex_cur[i];
        chk(overrun == exp_ovr, "R7/R8 overrun flag", overrun, exp_ovr);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED);
        for (int i = 0; i < N; i++) begin
            gm[i] = 16'sh4000; om[i] = '0; par_prev[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(ser_out == '0, "R10 reset stream", ser_out, 0);
        chk(par_out == '0, "R10 reset bank", par_out[0], 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);
        rst_n = 1'b1;

        // R10: default coefficients give a plain conversion.
        rand_bx();
        one_pass(0);

        // R3: program random gains and offsets.
        for (int i = 0; i < N; i++) begin
            gm[i] = 16'($urandom);
            om[i] = 32'($urandom);
            wr({1'b0, 4'(i)}, {16'($urandom), gm[i]});
            wr({1'b1, 4'(i)}, om[i]);
        end
        rand_bx();
        one_pass(0);
        rand_bx();
        one_pass(0);

        // R8: second sync exactly 17 cycles after the first.
        rand_bx();
        calc_nxt();
        for (int i = 0; i < N; i++) ex_cur[i] = ex_nxt[i];
        fire();
        observe(1, 18, 0, 1);
        for (int i = 0; i < N; i++) begin par_prev[i] = ex_cur[i]; ex_cur[i] = ex_nxt[i]; end
        observe(2, 22, 0, 0);
        for (int i = 0; i < N; i++) par_prev[i] = ex_cur[i];
        chk(overrun == 1'b0, "R8 no overrun at period 17", overrun, 0);

        // R6/R7: early sync and input change during a pass.
        rand_bx();
        one_pass(1);

        // R2 corners: extremes, exact zero, rounding ties.
        for (int i = 0; i < N; i++) begin gm[i] = 16'($urandom); om[i] = 32'($urandom); end
        rand_bx();
        bx[0] = 16'sh7FFF; gm[0] = 16'sh7FFF; om[0] = 32'sh7FFFFFFF;
        bx[1] = 16'sh8000; gm[1] = 16'sh8000; om[1] = 32'sh80000000;
        bx[2] = 16'sh1234; gm[2] = 16'sh0000; om[2] = 32'sh0;
        bx[3] = 16'sh0001; gm[3] = 16'sh0000; om[3] = 32'sh02000002;
        bx[4] = 16'sh0001; gm[4] = 16'sh0000; om[4] = 32'sh02000006;
        bx[5] = 16'sh7FFF; gm[5] = 16'sh8000; om[5] = 32'sh80000000;
        bx[6] = 16'sh0001; gm[6] = 16'sh0000; om[6] = 32'sh02000001;
        bx[7] = 16'sh0000; gm[7] = 16'sh4000; om[7] = 32'shFFFFFFFF;
        for (int i = 0; i < N; i++) begin
            wr({1'b0, 4'(i)}, {16'hFFFF, gm[i]});
            wr({1'b1, 4'(i)}, om[i]);
        end
        one_pass(0);

        repeat (4) @(negedge clk);
        report();
    end
endmodule